// File: doc/BRIEF.md
# Row-Buffer-Locality Migration Decider

This block watches the request stream headed for a large, slow memory in which every bank keeps one open row. It decides which rows are worth copying into a small, fast cache memory. Rows are moved in fixed 1 KB units. Each row is named by a bank and a row index. A row that keeps hitting in its bank's open row already gets near-fast latency, so the block does not count those hits. It counts row-buffer misses instead. A row qualifies for copying when it misses often and is reused often.

For each bank the block remembers which row is open and classifies every request as a hit or a miss. A small fully associative table holds miss counts for recently touched rows and replaces its least recently used entry. When a tracked row's count reaches the current threshold, the block raises a migration request carrying bank and row on a valid/ready handshake. When that request is accepted, the row leaves the table.

All counts are cleared after a programmable number of cycles. At the end of each programmable interval, the threshold is nudged up or down by comparing the latency saved by the migrations of that interval against their cost.

Top module: `rbl_migrate_decider`

## Requirements
- R1: Each bank remembers the row of its last request. A request to that same row is a hit, and any other request (including the first to a bank after reset) is a miss. One cycle after a request, `class_valid_o` is 1 and `class_hit_o` carries 1 for a hit and 0 for a miss.
- R2: A row-buffer miss to a tracked row adds 1 to its count, and a hit leaves the count unchanged. A miss to an untracked row enters it into the table with a count of 1.
- R3: When a miss brings a tracked row's count to the current threshold or above, `mig_valid_o` rises in the following cycle with that row's bank and row. It then holds steady, with bank and row unchanged, until the cycle in which `mig_ready_i` is 1.
- R4: An accepted row is removed from the table. A later miss to it starts again at a count of 1, so it is never requested twice from one run of counts.
- R5: The table holds 16 rows. When it is full, a new miss replaces the least recently touched row that has no request outstanding. Both hits and misses count as touches.
- R6: Every `clear_period_i` cycles after reset (cycles counted from 1, so the clear comes on cycle `clear_period_i`, then again `clear_period_i` cycles later), all counts of rows without an outstanding request are cleared. A miss in that same cycle is counted after the clear and yields 1.
- R7: At the end of each `interval_i` cycles, benefit = (sum of counts of rows accepted in the interval) × (`slow_lat_i` − `fast_lat_i`) and cost = (accepted rows) × `mig_cost_i`. The threshold rises by 1 if benefit < cost. It falls by 1 if benefit > cost + `margin_i`. It is clamped to 1..15 and changes at no other time.
- R8: After a synchronous reset the threshold is 2, `mig_valid_o` and `class_valid_o` are 0, and both period counters restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | A request to the slow memory is present |
| req_bank_i | input | BANK_W (3) | Bank of the request |
| req_row_i | input | ROW_W (16) | Row of the request |
| clear_period_i | input | PER_W (32) | Cycles between count clears |
| interval_i | input | PER_W (32) | Cycles per threshold-tuning interval |
| slow_lat_i | input | LAT_W (8) | Row-miss latency of the slow memory |
| fast_lat_i | input | LAT_W (8) | Row-miss latency of the fast memory |
| mig_cost_i | input | COST_W (16) | Cost charged per migration |
| margin_i | input | COST_W (16) | Margin by which benefit must beat cost to lower the threshold |
| class_valid_o | output | 1 | A classification for last cycle's request is present |
| class_hit_o | output | 1 | That request hit the open row |
| mig_valid_o | output | 1 | Migration request present |
| mig_ready_i | input | 1 | Migration request accepted this cycle |
| mig_bank_o | output | BANK_W (3) | Bank of the row to migrate |
| mig_row_o | output | ROW_W (16) | Row to migrate |
| thresh_o | output | CNT_W (4) | Current miss threshold |

## Verification
The periodic clear of the counts and the counting of a new miss can land on the same clock edge. The bench releases reset with a clear period of 4. It misses a row on cycle 1 and misses it again on cycle 4, the clear cycle. The second miss must leave the count at 1 and raise no request, and a third miss on cycle 6 must then flag the row. A second row, last missed before the clear, must also restart at 1.

// File: rtl/rbl_pkg.sv
package rbl_pkg;

    typedef enum logic [1:0] {
        TUNE_HOLD,
        TUNE_RAISE,
        TUNE_LOWER
    } tune_e;

endpackage

// File: rtl/rbl_open_rows.sv
module rbl_open_rows #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    output logic              row_hit_o
);
    localparam int NB = 1 << BANK_W;

    typedef struct packed {
        logic [NB-1:0]            open;
        logic [NB-1:0][ROW_W-1:0] row;
    } st_t;

    st_t s_q, s_d;

    assign row_hit_o = s_q.open[req_bank_i] && (s_q.row[req_bank_i] == req_row_i);

    always_comb begin
        s_d = s_q;
        if (req_valid_i) begin
            s_d.open[req_bank_i] = 1'b1;
            s_d.row[req_bank_i]  = req_row_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R1: the bank just requested holds that row open afterwards
    p_open_update_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> (s_q.open[$past(req_bank_i)] && s_q.row[$past(req_bank_i)] == $past(req_row_i)));

endmodule

// File: rtl/rbl_period_tick.sv
module rbl_period_tick #(
    parameter int PER_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o
);
    logic [PER_W-1:0] cnt_q, cnt_d;

    assign tick_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_i};

    always_comb begin
        cnt_d = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rbl_miss_table.sv
module rbl_miss_table #(
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 16,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic              row_hit_i,
    input  logic              clear_i,
    input  logic [CNT_W-1:0]  thr_i,
    output logic              mig_valid_o,
    input  logic              mig_ready_i,
    output logic [BANK_W-1:0] mig_bank_o,
    output logic [ROW_W-1:0]  mig_row_o,
    output logic              acc_fire_o,
    output logic [CNT_W-1:0]  acc_cnt_o
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic              pend;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  age;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic               sel_valid;
        logic [IDX_W-1:0]   sel;
    } st_t;

    st_t s_q, s_d;

    logic             accept;
    logic             hit_any, free_ok, old_ok, touch;
    logic [IDX_W-1:0] hit_idx, free_idx, old_idx, best_age, tgt, tgt_age;

    assign mig_valid_o = s_q.sel_valid;
    assign mig_bank_o  = s_q.ent[s_q.sel].bank;
    assign mig_row_o   = s_q.ent[s_q.sel].row;
    assign acc_fire_o  = accept;
    assign acc_cnt_o   = s_q.ent[s_q.sel].cnt;

    always_comb begin
        s_d    = s_q;
        accept = s_q.sel_valid && mig_ready_i;

        // accepted row leaves the table
        if (accept) begin
            s_d.ent[s_q.sel].valid = 1'b0;
            s_d.ent[s_q.sel].pend  = 1'b0;
        end

        // periodic clear comes before this cycle's count
        if (clear_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (s_d.ent[i].valid && !s_d.ent[i].pend) s_d.ent[i].cnt = '0;
            end
        end

        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!hit_any && s_d.ent[i].valid && s_d.ent[i].bank == req_bank_i &&
                s_d.ent[i].row == req_row_i) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end

        // victim: a free slot first, else the oldest row with no request outstanding
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_ok && !s_d.ent[i].valid) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        old_ok   = 1'b0;
        old_idx  = '0;
        best_age = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (s_d.ent[i].valid && !s_d.ent[i].pend &&
                (!old_ok || s_d.ent[i].age > best_age)) begin
                old_ok   = 1'b1;
                old_idx  = IDX_W'(i);
                best_age = s_d.ent[i].age;
            end
        end

        touch = 1'b0;
        tgt   = '0;
        if (req_valid_i) begin
            if (hit_any) begin
                touch = 1'b1;
                tgt   = hit_idx;
                if (!row_hit_i && s_d.ent[hit_idx].cnt != '1)
                    s_d.ent[hit_idx].cnt = s_d.ent[hit_idx].cnt + 1'b1;
            end else if (!row_hit_i && (free_ok || old_ok)) begin
                touch = 1'b1;
                tgt   = free_ok ? free_idx : old_idx;
                s_d.ent[tgt].valid = 1'b1;
                s_d.ent[tgt].pend  = 1'b0;
                s_d.ent[tgt].bank  = req_bank_i;
                s_d.ent[tgt].row   = req_row_i;
                s_d.ent[tgt].cnt   = CNT_W'(1);
            end
            if (touch && !row_hit_i && !s_d.ent[tgt].pend && s_d.ent[tgt].cnt >= thr_i)
                s_d.ent[tgt].pend = 1'b1;
        end

        // recency ranks stay a permutation of 0..ENTRIES-1
        tgt_age = s_q.ent[tgt].age;
        if (touch) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (s_q.ent[j].age < tgt_age) s_d.ent[j].age = s_q.ent[j].age + 1'b1;
            end
            s_d.ent[tgt].age = '0;
        end

        // held selection: a new pick only when idle or after an accept
        if (!s_q.sel_valid || accept) begin
            s_d.sel_valid = 1'b0;
            s_d.sel       = '0;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (s_d.ent[i].valid && s_d.ent[i].pend) begin
                    s_d.sel_valid = 1'b1;
                    s_d.sel       = IDX_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
            for (int i = 0; i < ENTRIES; i++) s_q.ent[i].age <= IDX_W'(i);
        end else begin
            s_q <= s_d;
        end
    end

    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (s_q.ent[i].valid && s_q.ent[j].valid && s_q.ent[i].bank == s_q.ent[j].bank &&
                    s_q.ent[i].row == s_q.ent[j].row) dup = 1'b1;
            end
        end
    end

    // R4: a row is tracked at most once
    p_no_dup_r4: assert property (@(posedge clk) disable iff (rst) !dup);

    // R3: an offered request stays unchanged until taken
    p_mig_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mig_valid_o && !mig_ready_i) |=> (mig_valid_o && $stable(mig_bank_o) && $stable(mig_row_o)));

    // R3: the offered row is a tracked, flagged row
    p_sel_pending_r3: assert property (@(posedge clk) disable iff (rst)
        mig_valid_o |-> (s_q.ent[s_q.sel].valid && s_q.ent[s_q.sel].pend));

endmodule

// File: rtl/rbl_thresh_tuner.sv
module rbl_thresh_tuner
    import rbl_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int ACC_W  = 16,
    parameter int LAT_W  = 8,
    parameter int COST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              acc_fire_i,
    input  logic [CNT_W-1:0]  acc_cnt_i,
    input  logic [LAT_W-1:0]  slow_lat_i,
    input  logic [LAT_W-1:0]  fast_lat_i,
    input  logic [COST_W-1:0] mig_cost_i,
    input  logic [COST_W-1:0] margin_i,
    output logic [CNT_W-1:0]  thr_o
);
    localparam int AW1    = ACC_W + 1;
    localparam int WMAX   = (LAT_W > COST_W) ? LAT_W : COST_W;
    localparam int PROD_W = ACC_W + WMAX + 1;
    localparam logic [CNT_W-1:0] THR_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] THR_MIN  = CNT_W'(1);
    localparam logic [CNT_W-1:0] THR_INIT = CNT_W'(2);

    typedef struct packed {
        logic [ACC_W-1:0] miss_acc;
        logic [ACC_W-1:0] mig_acc;
        logic [CNT_W-1:0] thr;
    } st_t;

    st_t s_q, s_d;

    logic [AW1-1:0]    miss_wide, mig_wide;
    logic [ACC_W-1:0]  miss_sum, mig_sum;
    logic [LAT_W-1:0]  lat_gain;
    logic [PROD_W-1:0] benefit, cost, cost_hi;
    tune_e             dec;

    assign thr_o = s_q.thr;

    always_comb begin
        s_d       = s_q;
        miss_wide = {1'b0, s_q.miss_acc} + (acc_fire_i ? AW1'(acc_cnt_i) : '0);
        mig_wide  = {1'b0, s_q.mig_acc} + AW1'(acc_fire_i);
        miss_sum  = miss_wide[ACC_W] ? '1 : miss_wide[ACC_W-1:0];
        mig_sum   = mig_wide[ACC_W] ? '1 : mig_wide[ACC_W-1:0];
        lat_gain  = (slow_lat_i > fast_lat_i) ? slow_lat_i - fast_lat_i : '0;
        benefit   = PROD_W'(miss_sum) * PROD_W'(lat_gain);
        cost      = PROD_W'(mig_sum) * PROD_W'(mig_cost_i);
        cost_hi   = cost + PROD_W'(margin_i);

        if (benefit < cost)         dec = TUNE_RAISE;
        else if (benefit > cost_hi) dec = TUNE_LOWER;
        else                        dec = TUNE_HOLD;

        if (tick_i) begin
            s_d.miss_acc = '0;
            s_d.mig_acc  = '0;
            case (dec)
                TUNE_RAISE: if (s_q.thr != THR_MAX) s_d.thr = s_q.thr + 1'b1;
                TUNE_LOWER: if (s_q.thr > THR_MIN)  s_d.thr = s_q.thr - 1'b1;
                default:    s_d.thr = s_q.thr;
            endcase
        end else begin
            s_d.miss_acc = miss_sum;
            s_d.mig_acc  = mig_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.miss_acc <= '0;
            s_q.mig_acc  <= '0;
            s_q.thr      <= THR_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: threshold stays inside its clamp range
    p_thr_range_r7: assert property (@(posedge clk) disable iff (rst)
        (s_q.thr >= THR_MIN) && (s_q.thr <= THR_MAX));

    // R7: threshold moves only at an interval end
    p_thr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(s_q.thr));

    // R7: at most one step per interval end
    p_thr_step_r7: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (s_q.thr == $past(s_q.thr) || s_q.thr == $past(s_q.thr) + 1'b1 ||
                    s_q.thr == $past(s_q.thr) - 1'b1));

endmodule

// File: rtl/rbl_migrate_decider.sv
module rbl_migrate_decider #(
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 16,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 4,
    parameter int PER_W   = 32,
    parameter int LAT_W   = 8,
    parameter int COST_W  = 16,
    parameter int ACC_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [PER_W-1:0]  clear_period_i,
    input  logic [PER_W-1:0]  interval_i,
    input  logic [LAT_W-1:0]  slow_lat_i,
    input  logic [LAT_W-1:0]  fast_lat_i,
    input  logic [COST_W-1:0] mig_cost_i,
    input  logic [COST_W-1:0] margin_i,
    output logic              class_valid_o,
    output logic              class_hit_o,
    output logic              mig_valid_o,
    input  logic              mig_ready_i,
    output logic [BANK_W-1:0] mig_bank_o,
    output logic [ROW_W-1:0]  mig_row_o,
    output logic [CNT_W-1:0]  thresh_o
);
    typedef struct packed {
        logic valid;
        logic hit;
    } cls_t;

    cls_t cls_q, cls_d;

    logic             row_hit, clear_tick, tune_tick, acc_fire;
    logic [CNT_W-1:0] acc_cnt, thr;

    rbl_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_bank_i(req_bank_i),
        .req_row_i(req_row_i), .row_hit_o(row_hit)
    );

    rbl_period_tick #(.PER_W(PER_W)) u_clear (
        .clk(clk), .rst(rst), .period_i(clear_period_i), .tick_o(clear_tick)
    );

    rbl_period_tick #(.PER_W(PER_W)) u_interval (
        .clk(clk), .rst(rst), .period_i(interval_i), .tick_o(tune_tick)
    );

    rbl_miss_table #(.BANK_W(BANK_W), .ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_bank_i(req_bank_i),
        .req_row_i(req_row_i), .row_hit_i(row_hit), .clear_i(clear_tick), .thr_i(thr),
        .mig_valid_o(mig_valid_o), .mig_ready_i(mig_ready_i), .mig_bank_o(mig_bank_o),
        .mig_row_o(mig_row_o), .acc_fire_o(acc_fire), .acc_cnt_o(acc_cnt)
    );

    rbl_thresh_tuner #(.CNT_W(CNT_W), .ACC_W(ACC_W), .LAT_W(LAT_W), .COST_W(COST_W)) u_tune (
        .clk(clk), .rst(rst), .tick_i(tune_tick), .acc_fire_i(acc_fire), .acc_cnt_i(acc_cnt),
        .slow_lat_i(slow_lat_i), .fast_lat_i(fast_lat_i), .mig_cost_i(mig_cost_i),
        .margin_i(margin_i), .thr_o(thr)
    );

    assign thresh_o      = thr;
    assign class_valid_o = cls_q.valid;
    assign class_hit_o   = cls_q.hit;

    always_comb begin
        cls_d.valid = req_valid_i;
        cls_d.hit   = req_valid_i && row_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) cls_q <= '0;
        else     cls_q <= cls_d;
    end

    // R1: every request is classified one cycle later
    p_class_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> class_valid_o);

endmodule

// File: tb/rbl_migrate_decider_tb.sv
module rbl_migrate_decider_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [15:0] req_row = '0;
    logic [31:0] clear_period = 32'd1000000;
    logic [31:0] interval = 32'd1000000;
    logic [7:0]  slow_lat = 8'd20;
    logic [7:0]  fast_lat = 8'd5;
    logic [15:0] mig_cost = 16'd1000;
    logic [15:0] margin = 16'd0;
    logic        class_valid, class_hit, mig_valid;
    logic        mig_ready = 1'b0;
    logic [2:0]  mig_bank;
    logic [15:0] mig_row;
    logic [3:0]  thresh;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rbl_migrate_decider dut_i (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_bank_i(req_bank),
        .req_row_i(req_row), .clear_period_i(clear_period), .interval_i(interval),
        .slow_lat_i(slow_lat), .fast_lat_i(fast_lat), .mig_cost_i(mig_cost),
        .margin_i(margin), .class_valid_o(class_valid), .class_hit_o(class_hit),
        .mig_valid_o(mig_valid), .mig_ready_i(mig_ready), .mig_bank_o(mig_bank),
        .mig_row_o(mig_row), .thresh_o(thresh)
    );

    // {ready, bank, row, exp_hit, exp_mig_valid, exp_mig_bank, exp_mig_row}
    localparam logic [40:0] VEC [12] = '{
        {1'b0, 3'd0, 16'd5, 1'b0, 1'b0, 3'd0, 16'd0},
        {1'b0, 3'd0, 16'd5, 1'b1, 1'b0, 3'd0, 16'd0},
        {1'b0, 3'd0, 16'd5, 1'b1, 1'b0, 3'd0, 16'd0},
        {1'b0, 3'd1, 16'd5, 1'b0, 1'b0, 3'd0, 16'd0},
        {1'b0, 3'd0, 16'd7, 1'b0, 1'b0, 3'd0, 16'd0},
        {1'b0, 3'd0, 16'd5, 1'b0, 1'b1, 3'd0, 16'd5},
        {1'b1, 3'd1, 16'd9, 1'b0, 1'b0, 3'd0, 16'd0},
        {1'b0, 3'd0, 16'd7, 1'b0, 1'b1, 3'd0, 16'd7},
        {1'b1, 3'd0, 16'd7, 1'b1, 1'b0, 3'd0, 16'd0},
        {1'b0, 3'd0, 16'd5, 1'b0, 1'b0, 3'd0, 16'd0},
        {1'b0, 3'd1, 16'd5, 1'b0, 1'b1, 3'd1, 16'd5},
        {1'b1, 3'd1, 16'd5, 1'b1, 1'b0, 3'd0, 16'd0}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] b, input logic [15:0] r, input logic rdy);
        req_valid = v;
        req_bank  = b;
        req_row   = r;
        mig_ready = rdy;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        mig_ready = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 3'd0, 16'd0, 1'b0);
    endtask

    task automatic do_reset(input logic [31:0] clr, input logic [31:0] intv,
                            input logic [15:0] cost, input logic [15:0] mrg);
        clear_period = clr;
        interval     = intv;
        mig_cost     = cost;
        margin       = mrg;
        rst          = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(32'd1000000, 32'd1000000, 16'd1000, 16'd0);

        // R8: reset state
        chk("R8 mig_valid after reset", 32'(mig_valid), 0);
        chk("R8 class_valid after reset", 32'(class_valid), 0);
        chk("R8 threshold after reset", 32'(thresh), 2);

        // R1 R2 R3 R4: vector table at threshold 2
        for (int i = 0; i < 12; i++) begin
            logic [40:0] v;
            v = VEC[i];
            step(1'b1, v[39:37], v[36:21], v[40]);
            chk($sformatf("R1 class_valid vec %0d", i), 32'(class_valid), 1);
            chk($sformatf("R1 class_hit vec %0d", i), 32'(class_hit), 32'(v[20]));
            chk($sformatf("R2/R3/R4 mig_valid vec %0d", i), 32'(mig_valid), 32'(v[19]));
            if (v[19]) begin
                chk($sformatf("R3 mig_bank vec %0d", i), 32'(mig_bank), 32'(v[18:16]));
                chk($sformatf("R3 mig_row vec %0d", i), 32'(mig_row), 32'(v[15:0]));
            end
        end
        idle(1);
        chk("R1 class_valid clears when idle", 32'(class_valid), 0);

        // R5: LRU replacement in a full table
        do_reset(32'd1000000, 32'd1000000, 16'd1000, 16'd0);
        for (int i = 0; i < 17; i++) step(1'b1, 3'd0, 16'(100 + i), 1'b0);
        chk("R5 no request after filling", 32'(mig_valid), 0);
        step(1'b1, 3'd0, 16'd100, 1'b0);
        chk("R5 evicted row restarts at 1", 32'(mig_valid), 0);
        step(1'b1, 3'd0, 16'd102, 1'b0);
        chk("R5 kept row reaches threshold", 32'(mig_valid), 1);
        chk("R5 kept row id", 32'(mig_row), 102);
        step(1'b1, 3'd0, 16'd101, 1'b0);
        chk("R3 request held while not ready", 32'(mig_valid), 1);
        chk("R3 held row unchanged", 32'(mig_row), 102);

        // R6: periodic clear coinciding with a miss (period 4)
        do_reset(32'd4, 32'd1000000, 16'd1000, 16'd0);
        step(1'b1, 3'd2, 16'd1, 1'b0);
        step(1'b1, 3'd2, 16'd2, 1'b0);
        idle(1);
        step(1'b1, 3'd2, 16'd1, 1'b0);
        chk("R6 miss on clear cycle counts as 1", 32'(mig_valid), 0);
        step(1'b1, 3'd2, 16'd2, 1'b0);
        chk("R6 count cleared before later miss", 32'(mig_valid), 0);
        step(1'b1, 3'd2, 16'd1, 1'b0);
        chk("R6 second miss after clear flags", 32'(mig_valid), 1);
        chk("R6 flagged row", 32'(mig_row), 1);
        idle(2);
        chk("R6 outstanding request survives clear", 32'(mig_valid), 1);

        // R7: raise when cost exceeds benefit (2*15=30 < 1000)
        do_reset(32'd1000000, 32'd16, 16'd1000, 16'd0);
        step(1'b1, 3'd3, 16'd10, 1'b0);
        step(1'b1, 3'd3, 16'd11, 1'b0);
        step(1'b1, 3'd3, 16'd10, 1'b0);
        chk("R3 flag before raise", 32'(mig_valid), 1);
        step(1'b0, 3'd0, 16'd0, 1'b1);
        chk("R4 accepted request drops", 32'(mig_valid), 0);
        chk("R7 threshold unchanged mid interval", 32'(thresh), 2);
        idle(20);
        chk("R7 threshold raised", 32'(thresh), 3);
        step(1'b1, 3'd3, 16'd11, 1'b0);
        chk("R3 count 2 below threshold 3", 32'(mig_valid), 0);
        step(1'b1, 3'd3, 16'd10, 1'b0);
        step(1'b1, 3'd3, 16'd11, 1'b0);
        chk("R3 count 3 meets threshold 3", 32'(mig_valid), 1);
        chk("R3 row at threshold 3", 32'(mig_row), 11);

        // R7: lower when benefit beats cost+margin (30 > 1+5), then clamp at 1
        do_reset(32'd1000000, 32'd16, 16'd1, 16'd5);
        step(1'b1, 3'd3, 16'd10, 1'b0);
        step(1'b1, 3'd3, 16'd11, 1'b0);
        step(1'b1, 3'd3, 16'd10, 1'b0);
        step(1'b0, 3'd0, 16'd0, 1'b1);
        idle(20);
        chk("R7 threshold lowered", 32'(thresh), 1);
        step(1'b1, 3'd3, 16'd12, 1'b0);
        chk("R3 single miss flags at threshold 1", 32'(mig_valid), 1);
        chk("R3 row at threshold 1", 32'(mig_row), 12);
        step(1'b0, 3'd0, 16'd0, 1'b1);
        idle(20);
        chk("R7 threshold clamped at 1", 32'(thresh), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule